// File: doc/BRIEF.md
# Chainable SDI Scrambler and NRZI Word Coder

This block encodes one 10-bit video word per enabled clock for a serial digital video link. Each word goes through two stages, bit 0 first. The first stage is a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1. The second stage is an NRZ-to-NRZI converter with the polynomial x + 1. A run-time input switches each stage on or off, and a clock enable gates all state updates.

The block keeps no history of its own. The nine most recent scrambled bits arrive on a port, and so does the most recent NRZI bit. The updated histories leave through ports. The scrambler history leaves both combinationally and through a register, and the NRZI history leaves combinationally. This lets two copies be cross-chained into one 20-bit stream:
- The chroma copy takes the luma copy's registered scrambler history and bit 9 of the luma output.
- The luma copy takes the chroma copy's combinational histories.

Chroma therefore precedes luma on the serial line, and the pair places luma in the upper half of the 20-bit word. A single copy can also be chained to itself: feed its registered scrambler history and bit 9 of its output back to its history inputs.

Top module: `sdi_chain_coder`

## Requirements
- R1: An active-high asynchronous reset clears `dataOut` and `scrStateReg` to zero without waiting for a clock edge.
- R2: With scrambling on, scrambled bit i equals dataIn[i] XOR the scrambled bit 4 positions earlier XOR the scrambled bit 9 positions earlier in serial order. For positions before bit 0, the bits come from `scrHistIn`: bit 8 is the bit just before bit 0, and bit 0 is the oldest.
- R3: With NRZI on, output bit i equals scrambled bit i XOR NRZI bit i-1. For bit 0, the previous NRZI bit is `nrziHistIn`.
- R4: While `ce` is 0, `dataOut` and `scrStateReg` hold their values.
- R5: `scrStateNow` combinationally reports the last nine scrambled bits of the current word, with bit k holding scrambled bit k+1. `scrStateReg` takes that value on each clock with `ce` high.
- R6: `nrziStateNow` combinationally reports NRZI output bit 9 of the current word.
- R7: A disabled stage passes its input bits through unchanged. The history outputs still describe the bits that passed through: with both stages off, `scrStateNow` equals dataIn[9:1] and `nrziStateNow` equals dataIn[9].
- R8: `dataOut` is registered and shows the coded word one clock after the edge at which the word was presented with `ce` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Asynchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| scramOn | input | 1 | 1 turns the scrambler on |
| nrziOn | input | 1 | 1 turns NRZI conversion on |
| dataIn | input | 10 | Word to encode, bit 0 first in serial order |
| scrHistIn | input | 9 | Nine scrambled bits preceding this word, bit 8 newest |
| nrziHistIn | input | 1 | NRZI bit preceding this word |
| dataOut | output | 10 | Registered coded word |
| scrStateNow | output | 9 | Combinational scrambler history after this word |
| scrStateReg | output | 9 | Registered scrambler history |
| nrziStateNow | output | 1 | Combinational NRZI history after this word |

## Verification
The clocked assertions assume the following about the inputs:
- The history ports, mode inputs and data are stable and known at each rising edge.
- Reset is released away from a clock edge.
- The single-bit NRZI and scrambler checks apply only in the mode where the other stage is off.

The bench drives every input at the falling edge and samples at the next falling edge. It releases reset only at a falling edge. For the chained run, it builds each history from the block's own registered outputs, the way a cross-chained pair would.

// File: rtl/sdi_chain_pkg.sv
package sdi_chain_pkg;
  // Scrambler polynomial x^9 + x^4 + 1: history depth and short tap distance
  localparam int HIST_W = 9;
  localparam int TAP_D  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic scramOn;
    logic nrziOn;
  } coder_strb_t;
endpackage

// File: rtl/sdi_chain_ctrl.sv
module sdi_chain_ctrl
  import sdi_chain_pkg::*;
(
  input  logic        ce,
  input  logic        scramOn,
  input  logic        nrziOn,
  output coder_strb_t strb
);
  always_comb begin
    strb.load    = ce;
    strb.scramOn = scramOn;
    strb.nrziOn  = nrziOn;
  end
endmodule

// File: rtl/sdi_chain_dp.sv
module sdi_chain_dp
  import sdi_chain_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  coder_strb_t       strb,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [HIST_W-1:0] scrHistIn,
  input  logic              nrziHistIn,
  output logic [WORD_W-1:0] dataOut,
  output logic [HIST_W-1:0] scrStateNow,
  output logic [HIST_W-1:0] scrStateReg,
  output logic              nrziStateNow
);
  localparam int EXT_W = WORD_W + HIST_W;

  logic [EXT_W-1:0]  serialBits;   // history then this word, oldest at bit 0
  logic [WORD_W-1:0] nrziBits;
  logic              prevNrzi;

  // Bit-serial unroll of both stages, bit 0 first
  always_comb begin
    serialBits = '0;
    serialBits[HIST_W-1:0] = scrHistIn;
    for (int i = 0; i < WORD_W; i++) begin
      if (strb.scramOn)
        serialBits[HIST_W+i] = dataIn[i] ^ serialBits[i+HIST_W-TAP_D] ^ serialBits[i];
      else
        serialBits[HIST_W+i] = dataIn[i];
    end
    prevNrzi = nrziHistIn;
    nrziBits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      nrziBits[i] = strb.nrziOn ? (serialBits[HIST_W+i] ^ prevNrzi) : serialBits[HIST_W+i];
      prevNrzi    = nrziBits[i];
    end
  end

  assign scrStateNow  = serialBits[EXT_W-1:EXT_W-HIST_W];
  assign nrziStateNow = nrziBits[WORD_W-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dataOut     <= '0;
      scrStateReg <= '0;
    end else if (strb.load) begin
      dataOut     <= nrziBits;
      scrStateReg <= serialBits[EXT_W-1:EXT_W-HIST_W];
    end
  end
endmodule

// File: rtl/sdi_chain_coder.sv
module sdi_chain_coder
  import sdi_chain_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              scramOn,
  input  logic              nrziOn,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [HIST_W-1:0] scrHistIn,
  input  logic              nrziHistIn,
  output logic [WORD_W-1:0] dataOut,
  output logic [HIST_W-1:0] scrStateNow,
  output logic [HIST_W-1:0] scrStateReg,
  output logic              nrziStateNow
);
  coder_strb_t strb;

  sdi_chain_ctrl i_ctrl (
    .ce(ce), .scramOn(scramOn), .nrziOn(nrziOn), .strb(strb)
  );

  sdi_chain_dp #(.WORD_W(WORD_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(dataIn),
    .scrHistIn(scrHistIn), .nrziHistIn(nrziHistIn),
    .dataOut(dataOut), .scrStateNow(scrStateNow),
    .scrStateReg(scrStateReg), .nrziStateNow(nrziStateNow)
  );

  // R2: first scrambled bit with NRZI off
  a_r2_first_bit: assert property (@(posedge clk) disable iff (rst)
    (ce && scramOn && !nrziOn) |=>
      dataOut[0] == ($past(dataIn[0]) ^ $past(scrHistIn[HIST_W-TAP_D]) ^ $past(scrHistIn[0])));

  // R3: first NRZI bit with scrambler off
  a_r3_first_nrzi: assert property (@(posedge clk) disable iff (rst)
    (ce && nrziOn && !scramOn) |=> dataOut[0] == ($past(dataIn[0]) ^ $past(nrziHistIn)));

  // R4: registers hold without clock enable
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dataOut) && $stable(scrStateReg)));

  // R5: registered history follows the combinational one
  a_r5_state_capture: assert property (@(posedge clk) disable iff (rst)
    ce |=> scrStateReg == $past(scrStateNow));

  // R7: both stages off leave histories tracking the raw word
  a_r7_bypass_hist: assert property (@(posedge clk) disable iff (rst)
    (!scramOn && !nrziOn) |->
      (scrStateNow == dataIn[WORD_W-1 -: HIST_W] && nrziStateNow == dataIn[WORD_W-1]));

  // R8: bypass word appears after one clock
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (ce && !scramOn && !nrziOn) |=> dataOut == $past(dataIn));
endmodule

// File: tb/test_sdi_chain_coder.sv
module test_sdi_chain_coder;
  localparam int W = 10;
  localparam int H = 9;
  localparam int NVEC = 8;

  // Vector: {data, scrHist, nrziHist, scramOn, nrziOn}
  localparam logic [21:0] VECS [NVEC] = '{
    {10'h000, 9'h000, 1'b0, 1'b1, 1'b1},
    {10'h3FF, 9'h000, 1'b0, 1'b1, 1'b1},
    {10'h000, 9'h1FF, 1'b1, 1'b1, 1'b1},
    {10'h2A5, 9'h0C3, 1'b0, 1'b1, 1'b0},
    {10'h15A, 9'h121, 1'b1, 1'b0, 1'b1},
    {10'h3C1, 9'h0F0, 1'b1, 1'b0, 1'b0},
    {10'h001, 9'h021, 1'b0, 1'b1, 1'b1},
    {10'h200, 9'h100, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, scramOn = 1'b0, nrziOn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [H-1:0] scrHistIn = '0;
  logic nrziHistIn = 1'b0;
  logic [W-1:0] dataOut;
  logic [H-1:0] scrStateNow, scrStateReg;
  logic nrziStateNow;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdi_chain_coder i_sdi_chain_coder (
    .clk(clk), .rst(rst), .ce(ce), .scramOn(scramOn), .nrziOn(nrziOn),
    .dataIn(dataIn), .scrHistIn(scrHistIn), .nrziHistIn(nrziHistIn),
    .dataOut(dataOut), .scrStateNow(scrStateNow),
    .scrStateReg(scrStateReg), .nrziStateNow(nrziStateNow)
  );

  // Reference from the requirements: returns {nrziLast, scrHist[8:0], word[9:0]}
  function automatic logic [19:0] refCode(logic [W-1:0] d, logic [H-1:0] h,
                                          logic nh, logic sOn, logic nOn);
    logic [W+H-1:0] s;
    logic [W-1:0] n;
    logic p;
    s = '0; s[H-1:0] = h;
    for (int i = 0; i < W; i++)
      s[H+i] = sOn ? (d[i] ^ s[H+i-4] ^ s[H+i-9]) : d[i];
    p = nh;
    for (int i = 0; i < W; i++) begin
      n[i] = nOn ? (s[H+i] ^ p) : s[H+i];
      p = n[i];
    end
    return {n[W-1], s[W+H-1:W], n};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [19:0] r;
    logic [W-1:0] holdOut;
    logic [H-1:0] holdSt, modH;
    logic modN;
    logic [W-1:0] seed;
    // R1: reset state
    #2;
    chk("R1 reset dataOut", 32'(dataOut), 0);
    chk("R1 reset scrStateReg", 32'(scrStateReg), 0);
    @(negedge clk); rst = 1'b0;

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      {dataIn, scrHistIn, nrziHistIn, scramOn, nrziOn} = VECS[v];
      ce = 1'b1;
      r = refCode(dataIn, scrHistIn, nrziHistIn, scramOn, nrziOn);
      #1;
      chk("R5 scrStateNow", 32'(scrStateNow), 32'(r[18:10]));
      chk("R6 nrziStateNow", 32'(nrziStateNow), 32'(r[19]));
      @(posedge clk); @(negedge clk);
      chk("R8 R2 R3 R7 dataOut", 32'(dataOut), 32'(r[9:0]));
      chk("R5 scrStateReg", 32'(scrStateReg), 32'(r[18:10]));
    end

    // R7: both stages off, histories track raw data
    scramOn = 0; nrziOn = 0; dataIn = 10'h2F3; scrHistIn = 9'h1AB; nrziHistIn = 1;
    #1;
    chk("R7 bypass scrStateNow", 32'(scrStateNow), 32'(10'h2F3 >> 1));
    chk("R7 bypass nrziStateNow", 32'(nrziStateNow), 32'd1);

    // R4: hold with ce low
    @(posedge clk); @(negedge clk);
    holdOut = dataOut; holdSt = scrStateReg;
    ce = 0; scramOn = 1; nrziOn = 1; dataIn = 10'h0D2; scrHistIn = 9'h033;
    @(posedge clk); @(negedge clk);
    chk("R4 hold dataOut", 32'(dataOut), 32'(holdOut));
    chk("R4 hold scrStateReg", 32'(scrStateReg), 32'(holdSt));
    ce = 1;

    // R1: asynchronous reset between edges
    #2 rst = 1; #1;
    chk("R1 async dataOut", 32'(dataOut), 0);
    chk("R1 async scrStateReg", 32'(scrStateReg), 0);
    @(negedge clk); rst = 0;

    // Self-chained run: histories fed back from registered outputs
    modH = '0; modN = 0; seed = 10'h155;
    scramOn = 1; nrziOn = 1; ce = 1;
    for (int k = 0; k < 40; k++) begin
      seed = (seed * 10'd37) + 10'd11;
      dataIn = (k < 12) ? 10'h000 : seed;
      scrHistIn = scrStateReg; nrziHistIn = dataOut[W-1];
      r = refCode(dataIn, modH, modN, 1'b1, 1'b1);
      @(posedge clk); @(negedge clk);
      chk("R2 R3 chained dataOut", 32'(dataOut), 32'(r[9:0]));
      chk("R5 chained scrStateReg", 32'(scrStateReg), 32'(r[18:10]));
      modH = r[18:10]; modN = r[19];
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule